// File: doc/BRIEF.md
# Address Table Violation Capture

This block sits next to an address table and keeps a record of the first fault the table reports. The table raises four kinds of fault: an entry aged out, a port that is not a member, a lookup miss, and a full table. Each event arrives as a one-cycle pulse. The pulse carries the MAC address involved, a port vector and the ID of the source port. The block latches the first event together with its context and holds a level interrupt toward the host until the host collects it. Any event that arrives while one is already held is dropped, and an overflow bit records the loss.

The host collects the fault through the same command, data and MAC registers it uses for table operations. It issues a get-and-clear opcode on the shared command port. This opcode follows the same busy handshake as every other table command. When the busy period ends, the held fault is copied into the readout registers and the pending state is cleared. The readout fields are the kind flags, the overflow bit, a data word and the MAC address. In the data word, the source port ID takes the low bits that a normal table read uses for the entry state, and the port vector sits directly above it.

Top module: `vcap_top`

## Requirements
- R1: After reset, irq_o, busy_o, vflags_o, vovf_o, data_o and mac_o are all zero.
- R2: A cycle with ev_kind_i nonzero and nothing pending latches the kind bits (all set bits together), MAC, port vector and source port ID. irq_o is high from the next cycle. Kind bit 0 is full, bit 1 miss, bit 2 member and bit 3 age-out.
- R3: While a fault is pending and no clear completes, further events are dropped and leave the held details unchanged. They set an internal overflow bit.
- R4: cmd_go_i with cmd_op_i equal to 3'b111 (get-and-clear) while idle raises busy_o from the next cycle. busy_o stays high for exactly LAT cycles (default 3).
- R5: On the cycle busy_o falls, the readout registers show the held fault. vflags_o shows the kind bits and vovf_o the overflow bit. data_o carries the source port ID in bits [SP_W-1:0] and the port vector in bits [SP_W+PV_W-1:SP_W], with zero above. mac_o shows the MAC address.
- R6: irq_o is low from the cycle after completion, and the overflow bit is cleared, unless R7 applies.
- R7: An event in the same cycle as completion is captured as a new fault, not lost. irq_o stays high, and the next get-and-clear returns it with vovf_o zero.
- R8: A get-and-clear with nothing pending completes normally and returns zero in vflags_o, vovf_o, data_o and mac_o.
- R9: cmd_go_i with any other opcode, and cmd_go_i while busy_o is high, is ignored. It starts no busy period, changes no readout register and leaves the pending fault intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_kind_i | input | 4 | Fault kind bits of an event pulse, zero when idle |
| ev_mac_i | input | 48 | MAC address of the event |
| ev_portvec_i | input | PV_W | Port vector of the event |
| ev_spid_i | input | SP_W | Source port ID of the event |
| cmd_go_i | input | 1 | Command strobe from the shared command port |
| cmd_op_i | input | 3 | Command opcode |
| busy_o | output | 1 | Command in progress |
| vflags_o | output | 4 | Kind flags of the collected fault |
| vovf_o | output | 1 | Overflow bit of the collected fault |
| data_o | output | DATA_W | Data word: source port ID low, port vector above |
| mac_o | output | 48 | MAC address of the collected fault |
| irq_o | output | 1 | Level interrupt, high while a fault is pending |

## Verification
The bench aims an event exactly at the completion edge. A design that cleared after capturing would lose that fault and drop the interrupt. It sends a second and third fault while one is pending. A design that overwrote the held fault would return the later MAC and omit the overflow bit. It also collects with nothing pending, where a design that copied stale context would return old data. Finally, it strobes foreign opcodes and keeps the strobe high through a busy period. A design that decoded loosely would start a command, clear the fault or stretch busy_o beyond LAT cycles.

// File: rtl/vcap_pkg.sv
// Shared constants for the violation capture block.
package vcap_pkg;
    localparam int MAC_W  = 48;
    localparam int KIND_W = 4;
    localparam int OP_W   = 3;

    // Opcode that collects and clears the held fault.
    localparam logic [OP_W-1:0] OP_GET_CLR_VIOL = 3'b111;

    // Kind bit positions.
    localparam int K_FULL   = 0;
    localparam int K_MISS   = 1;
    localparam int K_MEMBER = 2;
    localparam int K_AGE    = 3;
endpackage

// File: rtl/vcap_seq.sv
// Command sequencer: accepts a get-and-clear strobe while idle, holds busy
// for LAT cycles and flags the completing cycle.
// Assumes LAT >= 1 and that other opcodes are served elsewhere.
module vcap_seq
    import vcap_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [OP_W-1:0] op_i,
    output logic            busy_o,
    output logic            done_o
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CW-1:0] cnt_q;
    logic          start;

    // Accept only the collecting opcode, and only while idle.
    assign start  = go_i && !busy_o && (op_i == OP_GET_CLR_VIOL);
    assign done_o = busy_o && (cnt_q == '0);

    // Busy flag and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_o <= 1'b1;
            cnt_q  <= CW'(LAT - 1);
        end else if (done_o) begin
            busy_o <= 1'b0;
        end else if (busy_o) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R4: a accepted strobe raises busy on the next cycle
    a_r4_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o && op_i == OP_GET_CLR_VIOL) |=> busy_o);

    // R9: a foreign opcode while idle starts nothing
    a_r9_foreign_op: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(go_i && op_i == OP_GET_CLR_VIOL)) |=> !busy_o);
endmodule

// File: rtl/vcap_latch.sv
// First-fault latch: holds the first event and its context until a clear.
// Further events raise overflow. An event in the clear cycle becomes the
// new held fault. Assumes ev_kind_i is zero on cycles without an event.
module vcap_latch
    import vcap_pkg::*;
#(
    parameter int PV_W = 11,
    parameter int SP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] ev_kind_i,
    input  logic [MAC_W-1:0]  ev_mac_i,
    input  logic [PV_W-1:0]   ev_pv_i,
    input  logic [SP_W-1:0]   ev_sp_i,
    input  logic              clr_i,
    output logic              pend_o,
    output logic              ovf_o,
    output logic [KIND_W-1:0] kind_o,
    output logic [MAC_W-1:0]  mac_o,
    output logic [PV_W-1:0]   pv_o,
    output logic [SP_W-1:0]   sp_o
);
    logic ev;
    logic take;

    assign ev   = |ev_kind_i;
    // Capture when the slot is free or is being freed this cycle.
    assign take = ev && (!pend_o || clr_i);

    // Pending and overflow state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else if (clr_i) begin
            pend_o <= ev;
            ovf_o  <= 1'b0;
        end else if (ev) begin
            pend_o <= 1'b1;
            if (pend_o) ovf_o <= 1'b1;
        end
    end

    // Context registers of the held fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_o <= '0;
            mac_o  <= '0;
            pv_o   <= '0;
            sp_o   <= '0;
        end else if (take) begin
            kind_o <= ev_kind_i;
            mac_o  <= ev_mac_i;
            pv_o   <= ev_pv_i;
            sp_o   <= ev_sp_i;
        end
    end

    // R3: held details stay put while pending and not cleared
    a_r3_hold_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> ($stable(mac_o) && $stable(kind_o) && $stable(sp_o)));

    // R3: a dropped event records overflow
    a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i && ev) |=> ovf_o);

    // R7: an event during the clear keeps the slot occupied
    a_r7_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ev) |=> (pend_o && !ovf_o));
endmodule

// File: rtl/vcap_readout.sv
// Readout registers shared with table operations: loaded on completion
// with the held fault, or with zeros when nothing is held.
module vcap_readout
    import vcap_pkg::*;
#(
    parameter int PV_W   = 11,
    parameter int SP_W   = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              pend_i,
    input  logic              ovf_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [MAC_W-1:0]  mac_i,
    input  logic [PV_W-1:0]   pv_i,
    input  logic [SP_W-1:0]   sp_i,
    output logic [KIND_W-1:0] flags_o,
    output logic              ovf_o,
    output logic [DATA_W-1:0] data_o,
    output logic [MAC_W-1:0]  mac_o
);
    localparam int PAD_W = DATA_W - PV_W - SP_W;

    logic [DATA_W-1:0] word;

    // Data word layout: source port ID in the state slot, vector above.
    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, pv_i, sp_i};
        end else begin : g_nopad
            assign word = {pv_i, sp_i};
        end
    endgenerate

    // Copy the held fault out when a collecting command completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
            ovf_o   <= 1'b0;
            data_o  <= '0;
            mac_o   <= '0;
        end else if (load_i) begin
            flags_o <= pend_i ? kind_i : '0;
            ovf_o   <= pend_i && ovf_i;
            data_o  <= pend_i ? word : '0;
            mac_o   <= pend_i ? mac_i : '0;
        end
    end

    // R9: readout registers change only on a completion
    a_r9_readout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(flags_o) && $stable(data_o) && $stable(mac_o)));
endmodule

// File: rtl/vcap_top.sv
// Address table violation capture: first-fault latch, command sequencer
// for the get-and-clear opcode and the shared readout registers.
// Assumes event pulses last one cycle and carry valid context.
module vcap_top
    import vcap_pkg::*;
#(
    parameter int PV_W   = 11,
    parameter int SP_W   = 4,
    parameter int DATA_W = 16,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ev_kind_i,
    input  logic [47:0]       ev_mac_i,
    input  logic [PV_W-1:0]   ev_portvec_i,
    input  logic [SP_W-1:0]   ev_spid_i,
    input  logic              cmd_go_i,
    input  logic [2:0]        cmd_op_i,
    output logic              busy_o,
    output logic [3:0]        vflags_o,
    output logic              vovf_o,
    output logic [DATA_W-1:0] data_o,
    output logic [47:0]       mac_o,
    output logic              irq_o
);
    logic              done;
    logic              pend;
    logic              ovf;
    logic [KIND_W-1:0] kind;
    logic [MAC_W-1:0]  hmac;
    logic [PV_W-1:0]   hpv;
    logic [SP_W-1:0]   hsp;

    vcap_seq #(.LAT(LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_i(cmd_go_i), .op_i(cmd_op_i),
        .busy_o(busy_o), .done_o(done)
    );

    vcap_latch #(.PV_W(PV_W), .SP_W(SP_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ev_kind_i(ev_kind_i), .ev_mac_i(ev_mac_i),
        .ev_pv_i(ev_portvec_i), .ev_sp_i(ev_spid_i), .clr_i(done),
        .pend_o(pend), .ovf_o(ovf), .kind_o(kind), .mac_o(hmac),
        .pv_o(hpv), .sp_o(hsp)
    );

    vcap_readout #(.PV_W(PV_W), .SP_W(SP_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .load_i(done), .pend_i(pend), .ovf_i(ovf),
        .kind_i(kind), .mac_i(hmac), .pv_i(hpv), .sp_i(hsp),
        .flags_o(vflags_o), .ovf_o(vovf_o), .data_o(data_o), .mac_o(mac_o)
    );

    // Interrupt follows the pending state.
    assign irq_o = pend;

    // R2: the interrupt only rises after an event
    a_r2_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ev_kind_i != '0));

    // R6: the interrupt only falls at a completion
    a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $fell(busy_o));
endmodule

// File: tb/tb_vcap_top.sv
module tb_vcap_top;
    localparam int PERIOD = 10;
    localparam int PV_W = 11, SP_W = 4, DATA_W = 16, LAT = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] ev_kind = '0;
    logic [47:0] ev_mac = '0;
    logic [PV_W-1:0] ev_pv = '0;
    logic [SP_W-1:0] ev_sp = '0;
    logic cmd_go = 1'b0;
    logic [2:0] cmd_op = '0;
    logic busy, vovf, irq;
    logic [3:0] vflags;
    logic [DATA_W-1:0] data;
    logic [47:0] mac;

    vcap_top #(.PV_W(PV_W), .SP_W(SP_W), .DATA_W(DATA_W), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .ev_kind_i(ev_kind), .ev_mac_i(ev_mac),
        .ev_portvec_i(ev_pv), .ev_spid_i(ev_sp), .cmd_go_i(cmd_go),
        .cmd_op_i(cmd_op), .busy_o(busy), .vflags_o(vflags), .vovf_o(vovf),
        .data_o(data), .mac_o(mac), .irq_o(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [3:0] flags; logic ovf; logic [DATA_W-1:0] data;
        logic [47:0] mac; logic irq;
    } exp_t;
    exp_t  q_exp[$];
    string q_tag[$];
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Bench model of the held fault
    bit m_pend = 0, m_ovf = 0;
    logic [3:0] m_kind; logic [47:0] m_mac; logic [PV_W-1:0] m_pv; logic [SP_W-1:0] m_sp;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expectation when busy falls
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (prev_busy && !busy) begin
            if (q_exp.size() == 0) chk("R4 unexpected completion", 1, 0);
            else begin
                exp_t e; string t;
                e = q_exp.pop_front(); t = q_tag.pop_front();
                chk({t, " R5 flags"}, 64'(vflags), 64'(e.flags));
                chk({t, " R5 ovf"},   64'(vovf),   64'(e.ovf));
                chk({t, " R5 data"},  64'(data),   64'(e.data));
                chk({t, " R5 mac"},   64'(mac),    64'(e.mac));
                chk({t, " R6 irq"},   64'(irq),    64'(e.irq));
            end
        end
        prev_busy = busy;
    end

    task automatic send_ev(input logic [3:0] k, input logic [47:0] a,
                           input logic [PV_W-1:0] p, input logic [SP_W-1:0] s);
        @(negedge clk);
        ev_kind = k; ev_mac = a; ev_pv = p; ev_sp = s;
        @(negedge clk);
        ev_kind = '0;
        if (m_pend) m_ovf = 1;
        else begin m_pend = 1; m_kind = k; m_mac = a; m_pv = p; m_sp = s; end
        chk("R2 irq after event", 64'(irq), 1);
    endtask

    // Get-and-clear; optionally inject an event on the completion edge and
    // optionally hold the strobe through the busy period.
    task automatic getclr(input string tag, input bit coincide, input bit hold,
                          input logic [3:0] k2, input logic [47:0] a2);
        exp_t e;
        @(negedge clk);
        cmd_go = 1; cmd_op = 3'b111;
        e.flags = m_pend ? m_kind : '0;
        e.ovf   = m_pend && m_ovf;
        e.data  = m_pend ? DATA_W'({m_pv, m_sp}) : '0;
        e.mac   = m_pend ? m_mac : '0;
        e.irq   = coincide;
        q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk);
        if (!hold) cmd_go = 0;
        chk({tag, " R4 busy first cycle"}, 64'(busy), 1);
        repeat (LAT - 1) @(negedge clk);
        chk({tag, " R4 busy last cycle"}, 64'(busy), 1);
        cmd_go = 0;
        if (coincide) begin ev_kind = k2; ev_mac = a2; ev_pv = 11'h0F0; ev_sp = 4'h9; end
        @(negedge clk);
        ev_kind = '0;
        chk({tag, " R4 busy ends after LAT"}, 64'(busy), 0);
        m_ovf = 0;
        if (coincide) begin m_pend = 1; m_kind = k2; m_mac = a2; m_pv = 11'h0F0; m_sp = 4'h9; end
        else m_pend = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", 64'(irq), 0); chk("R1 busy", 64'(busy), 0);
        chk("R1 flags", 64'(vflags), 0); chk("R1 data", 64'(data), 0);
        chk("R1 mac", 64'(mac), 0); chk("R1 ovf", 64'(vovf), 0);
        rst_n = 1;
        // R8 collect with nothing pending
        getclr("R8 empty", 0, 0, '0, '0);
        // R2 single miss fault, R5 readout, R6 irq drops
        send_ev(4'b0010, 48'h0011_2233_4455, 11'h005, 4'h3);
        getclr("R5 miss", 0, 0, '0, '0);
        // R2 multiple kinds together; R3 overflow with later events dropped
        send_ev(4'b1100, 48'hAABB_CCDD_EEFF, 11'h7FF, 4'hA);
        send_ev(4'b0001, 48'h1234_5678_9ABC, 11'h001, 4'h1);
        send_ev(4'b1000, 48'h0F0F_0F0F_0F0F, 11'h400, 4'hF);
        chk("R3 irq still high", 64'(irq), 1);
        // R9 foreign opcode ignored
        @(negedge clk); cmd_go = 1; cmd_op = 3'b010;
        @(negedge clk); cmd_go = 0;
        chk("R9 foreign op no busy", 64'(busy), 0);
        chk("R9 foreign op keeps irq", 64'(irq), 1);
        chk("R9 foreign op keeps readout", 64'(mac), 64'h0011_2233_4455);
        getclr("R3 overflow", 0, 0, '0, '0);
        chk("R6 irq low after clear", 64'(irq), 0);
        // R7 event on the completion edge, strobe held (R9 go while busy)
        send_ev(4'b0100, 48'h5555_6666_7777, 11'h123, 4'h6);
        getclr("R7 coincide", 1, 1, 4'b1000, 48'hDEAD_BEEF_0001);
        chk("R7 irq kept", 64'(irq), 1);
        getclr("R7 new fault", 0, 0, '0, '0);
        chk("R6 irq low at end", 64'(irq), 0);
        repeat (3) @(negedge clk);
        chk("R4 queue drained", 64'(q_exp.size()), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule